// File: doc/BRIEF.md
# Accumulator Rotate Unit

This unit carries out the four single-bit accumulator rotates of an 8-bit CPU datapath: circular rotate right, rotate right through carry, circular rotate left, and rotate left through carry. A two-bit mode code picks the operation. The rotate works on the accumulator and flag byte held in the unit's own registers. The result is written back on the clock edge where the operation strobe is high.

Only part of the flag byte is rewritten. Sign, zero and parity/overflow pass through unchanged. Half-carry, subtract and the two unused flag bits are cleared. Carry receives the bit that left the accumulator.

A load port writes the accumulator and the flag byte directly. This lets the surrounding datapath seed the state, and successive rotates then chain on the registered result. While the strobe is high, the unit also reports the fixed cost of the operation in clock states.

Top module: `acc_rotate_unit`

## Requirements
- R1: Mode code 2'b00 (circular right) moves accumulator bit 0 into bit 7 and into carry (flag bit 0), and shifts bits 7..1 down by one place.
- R2: Mode code 2'b01 (right through carry) puts the carry held before the operation into bit 7, and moves accumulator bit 0 into carry; bits 7..1 shift down by one place.
- R3: Mode code 2'b10 (circular left) moves accumulator bit 7 into bit 0 and into carry, and shifts bits 6..0 up by one place.
- R4: Mode code 2'b11 (left through carry) puts the old carry into bit 0, and moves accumulator bit 7 into carry; bits 6..0 shift up by one place.
- R5: On every rotate, flag bits 7 (sign), 6 (zero) and 2 (parity/overflow) keep their previous values.
- R6: On every rotate, flag bits 4 (half-carry) and 1 (subtract) and the unused bits 5 and 3 become 0.
- R7: A rotate takes effect at the rising edge where `op_valid` is high. With both `op_valid` and `ld_en` low, the accumulator and flags hold.
- R8: With `ld_en` high at an edge, the accumulator takes `ld_acc` and the flags take `ld_flags`. This applies even when `op_valid` is also high, and the rotate is then dropped.
- R9: With `rst_n` low at a rising edge, the accumulator and flags become 0 (synchronous active-low reset).
- R10: `cost_cycles` shows 4 while `op_valid` is high, and 0 otherwise.
- R11: Back-to-back rotates on consecutive edges each work on the result that the previous edge registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load accumulator and flags from the load port |
| ld_acc | input | 8 | Accumulator value to load |
| ld_flags | input | 8 | Flag byte to load |
| op_valid | input | 1 | Perform the selected rotate at this edge |
| op_sel | input | 2 | Rotate mode code |
| acc_q | output | 8 | Registered accumulator |
| flags_q | output | 8 | Registered flag byte |
| cost_cycles | output | 3 | Clock states of the strobed operation, 0 when idle |

## Verification
Every accumulator value is swept in each of the four modes, each time under a random flag byte. This catches a swapped mode decode, a fill taken from the wrong end, and a through-carry rotate that uses the new carry in place of the old one; each of these corrupts bit 7 or bit 0 for half of the values. The random flags would expose a wrong keep mask, which shows up as a leaked half-carry, subtract or unused bit, or as a lost sign, zero or parity bit. A long chain of random modes without reload catches a design that rotates the load value rather than the registered state. Separate checks cover load-over-rotate priority, holding while idle, and the reset value.

// File: rtl/acc_rotate_pkg.sv
// Package: shared mode encoding and flag bit positions for the rotate unit.
// Assumes an 8-bit flag byte; bit positions are fixed because downstream
// condition logic decodes them.
package acc_rotate_pkg;

    localparam int FLAG_W = 8;

    // Flag bit positions
    localparam int FLAG_SIGN   = 7;
    localparam int FLAG_ZERO   = 6;
    localparam int FLAG_HALF   = 4;
    localparam int FLAG_PARITY = 2;
    localparam int FLAG_SUB    = 1;
    localparam int FLAG_CARRY  = 0;

    // Bits that survive a rotate unchanged
    localparam logic [FLAG_W-1:0] FLAG_KEEP_MASK =
        FLAG_W'((1 << FLAG_SIGN) | (1 << FLAG_ZERO) | (1 << FLAG_PARITY));

    // Mode code: bit 1 = direction (1 = left), bit 0 = through carry
    typedef enum logic [1:0] {
        MODE_CIRC_RIGHT  = 2'b00,
        MODE_CARRY_RIGHT = 2'b01,
        MODE_CIRC_LEFT   = 2'b10,
        MODE_CARRY_LEFT  = 2'b11
    } rot_mode_e;

endpackage

// File: rtl/acc_rotate_shifter.sv
// Module: single-place rotate of a DATA_W-bit word.
// Direction and fill source come from the mode; the bit that leaves the
// word is returned as carry_out. Purely combinational.
module acc_rotate_shifter #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic              carry_in,
    input  logic              go_left,
    input  logic              thru_carry,
    output logic [DATA_W-1:0] data_out,
    output logic              carry_out
);

    logic [DATA_W-1:0] right_w;
    logic [DATA_W-1:0] left_w;
    logic              right_fill;
    logic              left_fill;

    // Fill bit: old carry or the bit leaving the opposite end
    always_comb begin
        right_fill = thru_carry ? carry_in : data_in[0];
        left_fill  = thru_carry ? carry_in : data_in[DATA_W-1];
    end

    // Per-bit steering for both directions
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == DATA_W - 1) begin : g_top
            assign right_w[i] = right_fill;
        end else begin : g_rmid
            assign right_w[i] = data_in[i+1];
        end
        if (i == 0) begin : g_bot
            assign left_w[i] = left_fill;
        end else begin : g_lmid
            assign left_w[i] = data_in[i-1];
        end
    end

    // Direction select and outgoing bit
    always_comb begin
        data_out  = go_left ? left_w : right_w;
        carry_out = go_left ? data_in[DATA_W-1] : data_in[0];
    end

endmodule

// File: rtl/acc_rotate_flags.sv
// Module: builds the post-rotate flag byte.
// Keeps sign, zero and parity/overflow, clears every other bit, then
// inserts the outgoing bit as carry. Purely combinational.
module acc_rotate_flags
    import acc_rotate_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              carry_new,
    output logic [FLAG_W-1:0] flags_out
);

    // Masked merge of kept bits and new carry
    always_comb begin
        flags_out             = flags_in & FLAG_KEEP_MASK;
        flags_out[FLAG_CARRY] = carry_new;
    end

endmodule

// File: rtl/acc_rotate_regs.sv
// Module: accumulator and flag register pair.
// Load has priority over update; both clear on synchronous active-low reset.
module acc_rotate_regs
    import acc_rotate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_acc,
    input  logic [FLAG_W-1:0] ld_flags,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] acc_next,
    input  logic [FLAG_W-1:0] flags_next,
    output logic [DATA_W-1:0] acc_q,
    output logic [FLAG_W-1:0] flags_q
);

    // State update: reset, then load, then rotate result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (ld_en) begin
            acc_q   <= ld_acc;
            flags_q <= ld_flags;
        end else if (upd_en) begin
            acc_q   <= acc_next;
            flags_q <= flags_next;
        end
    end

endmodule

// File: rtl/acc_rotate_unit.sv
// Module: accumulator rotate unit (top).
// Decodes the mode, rotates the registered accumulator, rewrites the flags
// and stores both when op_valid is high. Reports the fixed operation cost.
module acc_rotate_unit
    import acc_rotate_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CYCLE_COST = 4,
    localparam int COST_W    = $clog2(CYCLE_COST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_acc,
    input  logic [FLAG_W-1:0] ld_flags,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    output logic [DATA_W-1:0] acc_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic [COST_W-1:0] cost_cycles
);

    rot_mode_e         mode;
    logic              go_left;
    logic              thru_carry;
    logic [DATA_W-1:0] acc_next;
    logic              carry_next;
    logic [FLAG_W-1:0] flags_next;

    // Mode decode into direction and fill source
    always_comb begin
        mode       = rot_mode_e'(op_sel);
        go_left    = (mode == MODE_CIRC_LEFT)  || (mode == MODE_CARRY_LEFT);
        thru_carry = (mode == MODE_CARRY_RIGHT) || (mode == MODE_CARRY_LEFT);
    end

    acc_rotate_shifter #(.DATA_W(DATA_W)) u_shift (
        .data_in    (acc_q),
        .carry_in   (flags_q[FLAG_CARRY]),
        .go_left    (go_left),
        .thru_carry (thru_carry),
        .data_out   (acc_next),
        .carry_out  (carry_next)
    );

    acc_rotate_flags u_flags (
        .flags_in  (flags_q),
        .carry_new (carry_next),
        .flags_out (flags_next)
    );

    acc_rotate_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_acc     (ld_acc),
        .ld_flags   (ld_flags),
        .upd_en     (op_valid),
        .acc_next   (acc_next),
        .flags_next (flags_next),
        .acc_q      (acc_q),
        .flags_q    (flags_q)
    );

    // Cost report while an operation is strobed
    always_comb begin
        cost_cycles = op_valid ? COST_W'(CYCLE_COST) : '0;
    end

endmodule

// File: rtl/acc_rotate_unit_chk.sv
// Module: assertion checker for acc_rotate_unit, attached by bind.
// Assumes the mode encoding and flag positions of acc_rotate_pkg.
module acc_rotate_unit_chk
    import acc_rotate_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COST_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [DATA_W-1:0] ld_acc,
    input logic [FLAG_W-1:0] ld_flags,
    input logic              op_valid,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] acc_q,
    input logic [FLAG_W-1:0] flags_q,
    input logic [COST_W-1:0] cost_cycles
);

    logic rot_now;
    assign rot_now = op_valid && !ld_en;

    AST_CIRC_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_now && op_sel == 2'b00) |=> (acc_q == {$past(acc_q[0]), $past(acc_q[DATA_W-1:1])}
            && flags_q[FLAG_CARRY] == $past(acc_q[0]))); // R1

    AST_CARRY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_now && op_sel == 2'b01) |=> (acc_q == {$past(flags_q[FLAG_CARRY]), $past(acc_q[DATA_W-1:1])}
            && flags_q[FLAG_CARRY] == $past(acc_q[0]))); // R2

    AST_CIRC_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_now && op_sel == 2'b10) |=> (acc_q == {$past(acc_q[DATA_W-2:0]), $past(acc_q[DATA_W-1])}
            && flags_q[FLAG_CARRY] == $past(acc_q[DATA_W-1]))); // R3

    AST_CARRY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_now && op_sel == 2'b11) |=> (acc_q == {$past(acc_q[DATA_W-2:0]), $past(flags_q[FLAG_CARRY])}
            && flags_q[FLAG_CARRY] == $past(acc_q[DATA_W-1]))); // R4

    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rot_now |=> ((flags_q & FLAG_KEEP_MASK) == ($past(flags_q) & FLAG_KEEP_MASK))); // R5

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rot_now |=> (flags_q[FLAG_HALF] == 1'b0 && flags_q[FLAG_SUB] == 1'b0
            && flags_q[5] == 1'b0 && flags_q[3] == 1'b0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !ld_en) |=> ($stable(acc_q) && $stable(flags_q))); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (acc_q == $past(ld_acc) && flags_q == $past(ld_flags))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_q == '0 && flags_q == '0)); // R9

    AST_COST_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (cost_cycles == COST_W'(4))); // R10

endmodule

bind acc_rotate_unit acc_rotate_unit_chk #(.DATA_W(DATA_W), .COST_W(COST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_en       (ld_en),
    .ld_acc      (ld_acc),
    .ld_flags    (ld_flags),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .acc_q       (acc_q),
    .flags_q     (flags_q),
    .cost_cycles (cost_cycles)
);

// File: tb/acc_rotate_unit_test.sv
// Bench: exhaustive accumulator sweep per mode with random flags, plus
// chained, priority, idle, reset and cost checks against an arithmetic model.
module acc_rotate_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_acc = '0;
    logic [7:0] ld_flags = '0;
    logic       op_valid = 1'b0;
    logic [1:0] op_sel = '0;
    logic [7:0] acc_q;
    logic [7:0] flags_q;
    logic [2:0] cost_cycles;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_rotate_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_acc(ld_acc),
        .ld_flags(ld_flags), .op_valid(op_valid), .op_sel(op_sel),
        .acc_q(acc_q), .flags_q(flags_q), .cost_cycles(cost_cycles)
    );

    // Expected result from the requirement text, bit arithmetic only
    function automatic logic [15:0] model(input logic [1:0] m, input logic [7:0] a, input logic [7:0] f);
        logic [7:0] na;
        logic       c;
        case (m)
            2'b00: begin na = (a >> 1) | (a << 7); c = a[0]; end
            2'b01: begin na = (a >> 1) | ({7'd0, f[0]} << 7); c = a[0]; end
            2'b10: begin na = (a << 1) | (a >> 7); c = a[7]; end
            default: begin na = (a << 1) | {7'd0, f[0]}; c = a[7]; end
        endcase
        return {na, (f & 8'hC4) | {7'd0, c}};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] e;
        logic [7:0]  ea, ef;
        // R9: reset clears state
        rst_n = 1'b0;
        ld_en = 1'b1; ld_acc = 8'hA5; ld_flags = 8'hFF;
        repeat (2) @(negedge clk);
        ld_en = 1'b0;
        check("R9 acc", acc_q, 8'h00);
        check("R9 flags", flags_q, 8'h00);
        check("R10 idle cost", {5'd0, cost_cycles}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R6, R10: exhaustive accumulator sweep per mode
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 256; a++) begin
                logic [7:0] rf;
                rf = 8'($urandom);
                ld_en = 1'b1; ld_acc = 8'(a); ld_flags = rf;
                @(negedge clk);
                ld_en = 1'b0; op_valid = 1'b1; op_sel = 2'(m);
                #1;
                check("R10 cost", {5'd0, cost_cycles}, 8'd4);
                @(negedge clk);
                op_valid = 1'b0;
                e = model(2'(m), 8'(a), rf);
                check(mode_req(2'(m)), acc_q, e[15:8]);
                check("R5 R6 flags", flags_q, e[7:0]);
            end
        end

        // R11: chained random rotates without reload
        ld_en = 1'b1; ld_acc = 8'h3C; ld_flags = 8'hFF;
        @(negedge clk);
        ld_en = 1'b0;
        ea = 8'h3C; ef = 8'hFF;
        for (int k = 0; k < 400; k++) begin
            op_valid = 1'b1; op_sel = 2'($urandom);
            e = model(op_sel, ea, ef);
            ea = e[15:8]; ef = e[7:0];
            @(negedge clk);
            check("R11 acc", acc_q, ea);
            check("R11 flags", flags_q, ef);
        end
        op_valid = 1'b0;

        // R7: idle holds state
        repeat (3) @(negedge clk);
        check("R7 acc hold", acc_q, ea);
        check("R7 flags hold", flags_q, ef);

        // R8: load wins over a simultaneous rotate
        ld_en = 1'b1; ld_acc = 8'h81; ld_flags = 8'h56; op_valid = 1'b1; op_sel = 2'b00;
        @(negedge clk);
        ld_en = 1'b0; op_valid = 1'b0;
        check("R8 acc", acc_q, 8'h81);
        check("R8 flags", flags_q, 8'h56);

        // R7: single strobed rotate after load
        op_valid = 1'b1; op_sel = 2'b11;
        @(negedge clk);
        op_valid = 1'b0;
        check("R7 R4 acc", acc_q, 8'h02);
        check("R7 R4 flags", flags_q, 8'h45);

        // R9: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 acc again", acc_q, 8'h00);
        check("R9 flags again", flags_q, 8'h00);
        @(negedge clk);
        finish_run();
    end

endmodule